// File: doc/BRIEF.md
# Four-Channel Trigger Combiner

The block turns the digitised comparator bits of four input channels into one trigger strobe for a waveform digitiser controller. Each comparator bit is brought into the clock domain by a two-flop synchroniser. Only its rising edge counts as a channel firing.

A configuration field selects which channels take part and how they combine. One mask holds the channels that may fire the trigger alone (OR). A second mask holds the channels that must all fire together (coincidence). "Together" means within a programmable window of clock cycles. The field sits in the upper half of a 32-bit control word, which is written over a simple register bus.

The strobe lasts one cycle. After it, the block stays quiet until the arm input is dropped and raised again.

Top module: `trig_combiner`

## Requirements
- R1: A write with `cfg_we` high and `cfg_addr` equal to 0x1E loads the trigger field from `cfg_wdata[31:16]`. A write to any other address leaves the configuration unchanged. Within the field, bits [3:0] are the OR mask (bit n is channel n), bits [7:4] are the coincidence mask (bit 4+n is channel n), bits [11:8] are the window, and bits [15:12] are ignored.
- R2: When armed, a rising edge on a channel in the OR mask raises `trig`. A comparator bit that changes just before clock edge k gives `trig` high after edge k+2 (three registers).
- R3: A rising edge on a channel that is in neither mask produces no trigger.
- R4: When armed, with a non-empty coincidence mask, `trig` fires when the last selected channel rises while every other selected channel rose within the window. The latency from that last edge is the same as in R2.
- R5: If any channel in the coincidence mask does not fire within the window, no trigger is produced.
- R6: The window is the number of cycles a channel edge stays counted after it arrives. A value of 0 or 1 means the edges must arrive in the same cycle. The value after reset is 1.
- R7: After reset both masks are empty and `trig` is low. While both masks are empty, no trigger is ever produced.
- R8: `trig` is high for exactly one cycle. After a trigger, or while `arm` is low, no trigger is produced. Firing resumes only after `arm` goes low and then high again.
- R9: A comparator bit held high gives a single edge, so it yields at most one trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| arm | input | 1 | Arm level; a rising edge re-enables the trigger |
| comp_in | input | 4 | Comparator bits, one per channel |
| trig | output | 1 | One-cycle trigger strobe |

## Verification
The assertions assume the configuration is not rewritten while a coincidence is being gathered, so the masks seen at a trigger are the ones that caused it. They also assume `arm` changes only between scenarios. The stimulus writes the configuration and re-arms only while all comparator bits are low and idle. It drives every input on the falling clock edge, so the OR and coincidence causes can be told apart by the masks that were active.

// File: rtl/trig_combiner.sv
module trig_combiner #(
  parameter int NCH      = 4,
  parameter int WIN_W    = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              arm,
  input  logic [NCH-1:0]    comp_in,
  output logic              trig
);
  localparam int OR_LSB  = 16;
  localparam int AND_LSB = OR_LSB + 4;
  localparam int WIN_LSB = AND_LSB + 4;

  logic [NCH-1:0]   or_m, and_m, s1, s2, prev, edge_v, held;
  logic [WIN_W-1:0] win, win_eff, load;
  logic             armed, arm_q, or_hit, and_hit, fire;
  logic             unused_bits;

  wire cfg_sel = cfg_we && (cfg_addr == CFG_ADDR);
  assign unused_bits = ^{cfg_wdata[OR_LSB-1:0], cfg_wdata[31:WIN_LSB+WIN_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      or_m  <= '0;
      and_m <= '0;
      win   <= WIN_W'(1);
    end else if (cfg_sel) begin
      or_m  <= cfg_wdata[OR_LSB  +: NCH];
      and_m <= cfg_wdata[AND_LSB +: NCH];
      win   <= cfg_wdata[WIN_LSB +: WIN_W];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, prev} <= '0;
    else begin
      s1   <= comp_in;
      s2   <= s1;
      prev <= s2;
    end

  assign edge_v  = s2 & ~prev;
  assign win_eff = (win == '0) ? WIN_W'(1) : win;
  assign load    = win_eff - WIN_W'(1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [WIN_W-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         cnt <= '0;
      else if (edge_v[i]) cnt <= load;
      else if (cnt != '0) cnt <= cnt - WIN_W'(1);
    assign held[i] = edge_v[i] | (cnt != '0);
  end

  assign or_hit  = |(edge_v & or_m);
  assign and_hit = (and_m != '0) && ((held & and_m) == and_m) && |(edge_v & and_m);
  assign fire    = armed && arm && (or_hit || and_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm_q <= 1'b0;
      armed <= 1'b0;
      trig  <= 1'b0;
    end else begin
      arm_q <= arm;
      trig  <= fire;
      if (!arm)               armed <= 1'b0;
      else if (arm && !arm_q) armed <= 1'b1;
      else if (fire)          armed <= 1'b0;
    end

  p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |=> (or_m == $past(cfg_wdata[OR_LSB +: NCH])) && (and_m == $past(cfg_wdata[AND_LSB +: NCH])));

  p_or_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past(and_m == '0)) |-> $past(|(s2 & ~prev & or_m)));

  p_and_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && $past((edge_v & or_m) == '0)) |-> $past((and_m != '0) && ((held & and_m) == and_m)));

  p_empty_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past((or_m != '0) || (and_m != '0)));

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  p_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> ($past(arm) && !armed));
endmodule

// File: tb/tb_trig_combiner.sv
module tb_trig_combiner;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, arm = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  comp_in = '0;
  logic        trig;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  trig_combiner dut (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .arm, .comp_in, .trig);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] a, input logic [15:0] fld);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = {fld, 16'hA5C3};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); arm = 1'b0;
    @(negedge clk); arm = 1'b1;
    @(negedge clk);
  endtask

  // Raise m0, raise m1 d cycles later; hold both high; count strobes.
  task automatic stim(input logic [3:0] m0, input logic [3:0] m1, input int d,
                      output int cnt, output int first);
    cnt = 0; first = -1;
    comp_in = comp_in | m0;
    if (d == 0) comp_in = comp_in | m1;
    for (int i = 1; i <= 14; i++) begin
      @(negedge clk);
      if (trig) begin
        if (cnt == 0) first = i;
        cnt++;
      end
      if (i == d) comp_in = comp_in | m1;
    end
    comp_in = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (trig) cnt++;
    end
  endtask

  task automatic t_reset();
    int c, f;
    check("R7 trig low after reset", trig, 0);
    rearm();
    stim(4'hF, 4'h0, 0, c, f);
    check("R7 empty masks give no trigger", c, 0);
  endtask

  task automatic t_cfg_addr();
    int c, f;
    write_cfg(8'h1C, 16'h0001);
    rearm();
    stim(4'h1, 4'h0, 0, c, f);
    check("R1 write to other address ignored", c, 0);
    write_cfg(8'h1E, 16'hF001);
    rearm();
    stim(4'h1, 4'h0, 0, c, f);
    check("R1 write to 0x1E loads OR mask", c, 1);
    check("R2 latency of three cycles", f, 3);
  endtask

  task automatic t_or();
    int c, f;
    write_cfg(8'h1E, 16'h0006);
    rearm();
    stim(4'h4, 4'h0, 0, c, f);
    check("R2 OR channel 2 fires", c, 1);
    check("R9 held level gives one trigger", c, 1);
    check("R2 OR latency", f, 3);
    rearm();
    stim(4'h9, 4'h0, 0, c, f);
    check("R3 unselected channels ignored", c, 0);
  endtask

  task automatic t_arm();
    int c, f;
    write_cfg(8'h1E, 16'h0002);
    rearm();
    stim(4'h2, 4'h0, 0, c, f);
    check("R8 first strobe", c, 1);
    stim(4'h2, 4'h0, 0, c, f);
    check("R8 no trigger before rearm", c, 0);
    @(negedge clk); arm = 1'b0;
    stim(4'h2, 4'h0, 0, c, f);
    check("R8 no trigger while arm low", c, 0);
    arm = 1'b1;
    @(negedge clk);
    stim(4'h2, 4'h0, 0, c, f);
    check("R8 fires after rearm", c, 1);
  endtask

  task automatic t_and();
    int c, f;
    write_cfg(8'h1E, 16'h0030);
    rearm();
    stim(4'h3, 4'h0, 0, c, f);
    check("R4 coincidence of channels 0 and 1", c, 1);
    check("R4 coincidence latency", f, 3);
    rearm();
    stim(4'h1, 4'h0, 0, c, f);
    check("R5 missing channel gives no trigger", c, 0);
    rearm();
    stim(4'h1, 4'h2, 1, c, f);
    check("R6 window 0 rejects one-cycle skew", c, 0);
    write_cfg(8'h1E, 16'h0130);
    rearm();
    stim(4'h1, 4'h2, 1, c, f);
    check("R6 window 1 rejects one-cycle skew", c, 0);
    write_cfg(8'h1E, 16'h0330);
    rearm();
    stim(4'h1, 4'h2, 2, c, f);
    check("R6 window 3 accepts two-cycle skew", c, 1);
    check("R4 fires on last edge", f, 5);
    rearm();
    stim(4'h1, 4'h2, 3, c, f);
    check("R5 window 3 rejects three-cycle skew", c, 0);
    rearm();
    stim(4'h4, 4'h8, 0, c, f);
    check("R3 channels outside coincidence mask ignored", c, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_addr();
    t_or();
    t_arm();
    t_and();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule